// File: doc/BRIEF.md
# Short-Immediate Instruction Decoder with Long-Immediate Prefix

This block decodes a stream of 16-bit instruction halfwords that use a register-plus-6-bit-immediate layout. Each halfword is formed from two stream bytes, with the first byte as the low half. A halfword whose top six bits carry the prefix code is not an instruction. It only supplies the upper ten bits of a 16-bit immediate. The next halfword then completes a long-form instruction.

For every complete instruction the block emits one record. The record holds an operation class, a register index, the assembled immediate and a 17-bit signed branch offset. It also carries a flag that says whether the instruction was one halfword or two, so that a fetch unit can advance its program counter by 2 or 4 bytes. Opcodes outside this format come out as class "unknown". A prefix followed by something that cannot complete it raises a one-cycle error pulse, and the pending prefix is dropped. Input is a valid/ready halfword stream. Output is a valid/ready record held by one register stage.

Top module: `sru6_dec`

## Requirements
- R1: A halfword is taken in as `{second byte, first byte}`. In the short form, bits 15:10 are the opcode, bits 9:6 are the register index and bits 5:0 are an unsigned immediate that is zero-extended to 16 bits. The record has `rec_long_o`=0.
- R2: A halfword with bits 15:10 = 111100 is a prefix. It is accepted and produces no record. The next halfword supplies the opcode, the register and immediate bits 5:0, while the prefix bits 9:0 become immediate bits 15:6. That record has `rec_long_o`=1, so the largest immediate is 65535.
- R3: The opcode maps to `rec_class_o` as follows: 010100→1 (store word, DP), 010101→2 (store word, SP), 010110→3 (load word, DP), 010111→4 (load word, SP), 011000→5 (load address, DP), 011001→6 (load address, SP), 011010→7 (load constant), 011011→8 (load word, CP), 111010→9 (set resource control), 011100→10 (branch-true forward), 011101→11 (branch-true backward), 011110→12 (branch-false forward), 011111→13 (branch-false backward).
- R4: `rec_offset_o` is a 17-bit two's-complement value. It is +immediate for classes 10 and 12, −immediate for classes 11 and 13, and 0 for every other class.
- R5: A halfword that is not a prefix and is not preceded by a prefix, and whose opcode is not in the R3 map, yields a record of class 0 with its register and immediate fields still extracted.
- R6: If a prefix is followed by another prefix, or by a halfword whose opcode is not in the R3 map, `err_o` pulses high for one cycle and no record is produced. Both halfwords are consumed and no prefix stays pending.
- R7: While `rec_valid_o`=1 and `rec_ready_i`=0, the record fields and `rec_valid_o` stay unchanged and `hw_ready_o`=0. Otherwise `hw_ready_o`=1.
- R8: Reset (`rst_ni` low) clears `rec_valid_o`, `err_o` and any pending prefix.
- R9: The record, or the error pulse, appears in the cycle after the clock edge that accepts the halfword completing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_valid_i | input | 1 | Halfword valid |
| hw_i | input | 16 | Halfword, low byte first in the stream |
| hw_ready_o | output | 1 | Decoder can accept a halfword |
| rec_valid_o | output | 1 | Decoded record valid |
| rec_ready_i | input | 1 | Downstream accepts the record |
| rec_class_o | output | 4 | Operation class (R3 codes, 0 = unknown) |
| rec_reg_o | output | 4 | Register index |
| rec_imm_o | output | 16 | Assembled unsigned immediate |
| rec_offset_o | output | 17 | Signed branch offset |
| rec_long_o | output | 1 | 1 = two-halfword form |
| err_o | output | 1 | One-cycle pulse on an orphaned prefix |

## Verification
The bench targets the boundaries of the merge and the sign handling. It uses the full 65535 immediate, both as a load-address and as a backward branch, where a design that loses a bit or negates into too narrow a field would report the wrong magnitude or sign. It sends a prefix followed by a prefix, and a prefix followed by an unknown opcode, then a plain short halfword. A design that kept the stale prefix would stamp upper immediate bits and the long flag onto that short instruction. A reset that lands between a prefix and its operand is checked the same way. A stalled consumer is held for several cycles with a new halfword waiting, to catch a design that overwrites the held record or accepts input it cannot store.

// File: rtl/sru6_pkg.sv
package sru6_pkg;
  localparam int HW_W   = 16;
  localparam int OPC_W  = 6;
  localparam int REG_W  = 4;
  localparam int LOW_W  = 6;
  localparam int PFX_W  = HW_W - OPC_W;
  localparam int IMM_W  = PFX_W + LOW_W;
  localparam int OFF_W  = IMM_W + 1;
  localparam int CLS_W  = 4;
  localparam logic [OPC_W-1:0] PREFIX_OPC = 6'b111100;

  typedef enum logic [CLS_W-1:0] {
    CLS_UNKNOWN = 4'd0,
    CLS_STW_DP  = 4'd1,
    CLS_STW_SP  = 4'd2,
    CLS_LDW_DP  = 4'd3,
    CLS_LDW_SP  = 4'd4,
    CLS_LDA_DP  = 4'd5,
    CLS_LDA_SP  = 4'd6,
    CLS_LDC     = 4'd7,
    CLS_LDW_CP  = 4'd8,
    CLS_SETRC   = 4'd9,
    CLS_BT_FWD  = 4'd10,
    CLS_BT_BWD  = 4'd11,
    CLS_BF_FWD  = 4'd12,
    CLS_BF_BWD  = 4'd13
  } op_class_e;

  typedef struct packed {
    op_class_e          cls;
    logic [REG_W-1:0]   rg;
    logic [IMM_W-1:0]   imm;
    logic [OFF_W-1:0]   off;
    logic               lng;
  } rec_t;
endpackage

// File: rtl/sru6_opc_dec.sv
module sru6_opc_dec
  import sru6_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output op_class_e        cls_o,
  output logic             known_o,
  output logic             prefix_o,
  output logic             branch_o,
  output logic             bwd_o
);
  always_comb begin
    unique case (opc_i)
      6'b010100: cls_o = CLS_STW_DP;
      6'b010101: cls_o = CLS_STW_SP;
      6'b010110: cls_o = CLS_LDW_DP;
      6'b010111: cls_o = CLS_LDW_SP;
      6'b011000: cls_o = CLS_LDA_DP;
      6'b011001: cls_o = CLS_LDA_SP;
      6'b011010: cls_o = CLS_LDC;
      6'b011011: cls_o = CLS_LDW_CP;
      6'b111010: cls_o = CLS_SETRC;
      6'b011100: cls_o = CLS_BT_FWD;
      6'b011101: cls_o = CLS_BT_BWD;
      6'b011110: cls_o = CLS_BF_FWD;
      6'b011111: cls_o = CLS_BF_BWD;
      default:   cls_o = CLS_UNKNOWN;
    endcase
  end

  assign known_o  = (cls_o != CLS_UNKNOWN);
  assign prefix_o = (opc_i == PREFIX_OPC);
  // branch group shares 0111xx; bit 0 selects backward
  assign branch_o = (opc_i[OPC_W-1:2] == 4'b0111);
  assign bwd_o    = branch_o & opc_i[0];
endmodule

// File: rtl/sru6_pfx_track.sv
module sru6_pfx_track
  import sru6_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             prefix_i,
  input  logic [PFX_W-1:0] bits_i,
  output logic             pend_o,
  output logic [PFX_W-1:0] pfx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      pfx_o  <= '0;
    end else if (take_i) begin
      // a pending prefix is always resolved (merged or dropped) by the next halfword
      pend_o <= ~pend_o & prefix_i;
      if (~pend_o & prefix_i) pfx_o <= bits_i;
    end
  end
endmodule

// File: rtl/sru6_rec_reg.sv
module sru6_rec_reg
  import sru6_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic fail_i,
  input  rec_t rec_i,
  input  logic ready_i,
  output logic valid_o,
  output rec_t rec_o,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rec_o   <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= fail_i;
      if (load_i) begin
        valid_o <= 1'b1;
        rec_o   <= rec_i;
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sru6_dec.sv
module sru6_dec
  import sru6_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hw_valid_i,
  input  logic [HW_W-1:0]    hw_i,
  output logic               hw_ready_o,
  output logic               rec_valid_o,
  input  logic               rec_ready_i,
  output logic [CLS_W-1:0]   rec_class_o,
  output logic [REG_W-1:0]   rec_reg_o,
  output logic [IMM_W-1:0]   rec_imm_o,
  output logic [OFF_W-1:0]   rec_offset_o,
  output logic               rec_long_o,
  output logic               err_o
);
  logic [OPC_W-1:0] opc;
  logic [REG_W-1:0] rg;
  logic [LOW_W-1:0] low;
  op_class_e        cls;
  logic             known, is_pfx, is_br, is_bwd;
  logic             take, pend, emit, fail;
  logic [PFX_W-1:0] pfx;
  logic [IMM_W-1:0] imm;
  logic [OFF_W-1:0] mag;
  rec_t             nxt, cur;

  assign opc = hw_i[HW_W-1 -: OPC_W];
  assign rg  = hw_i[LOW_W +: REG_W];
  assign low = hw_i[LOW_W-1:0];

  sru6_opc_dec u_opc (
    .opc_i    (opc),
    .cls_o    (cls),
    .known_o  (known),
    .prefix_o (is_pfx),
    .branch_o (is_br),
    .bwd_o    (is_bwd)
  );

  assign hw_ready_o = ~rec_valid_o | rec_ready_i;
  assign take       = hw_valid_i & hw_ready_o;

  sru6_pfx_track u_pfx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .prefix_i (is_pfx),
    .bits_i   (hw_i[PFX_W-1:0]),
    .pend_o   (pend),
    .pfx_o    (pfx)
  );

  assign emit = take & (pend ? known : ~is_pfx);
  assign fail = take & pend & ~known;

  assign imm = pend ? {pfx, low} : {{PFX_W{1'b0}}, low};
  assign mag = {1'b0, imm};

  always_comb begin
    nxt.cls = cls;
    nxt.rg  = rg;
    nxt.imm = imm;
    nxt.lng = pend;
    if (!is_br)      nxt.off = '0;
    else if (is_bwd) nxt.off = ~mag + 1'b1;
    else             nxt.off = mag;
  end

  sru6_rec_reg u_rec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (emit),
    .fail_i  (fail),
    .rec_i   (nxt),
    .ready_i (rec_ready_i),
    .valid_o (rec_valid_o),
    .rec_o   (cur),
    .err_o   (err_o)
  );

  assign rec_class_o  = cur.cls;
  assign rec_reg_o    = cur.rg;
  assign rec_imm_o    = cur.imm;
  assign rec_offset_o = cur.off;
  assign rec_long_o   = cur.lng;
endmodule

// File: rtl/sru6_dec_chk.sv
module sru6_dec_chk
  import sru6_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hw_valid_i,
  input logic [HW_W-1:0]  hw_i,
  input logic             hw_ready_o,
  input logic             rec_valid_o,
  input logic             rec_ready_i,
  input logic [CLS_W-1:0] rec_class_o,
  input logic [REG_W-1:0] rec_reg_o,
  input logic [IMM_W-1:0] rec_imm_o,
  input logic [OFF_W-1:0] rec_offset_o,
  input logic             rec_long_o,
  input logic             err_o
);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_class_o) && $stable(rec_reg_o)
      && $stable(rec_imm_o) && $stable(rec_offset_o) && $stable(rec_long_o));

  p_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |-> !hw_ready_o);

  p_short_imm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_long_o |-> rec_imm_o[IMM_W-1:LOW_W] == '0);

  p_prefix_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_valid_i && hw_ready_o && hw_i[HW_W-1 -: OPC_W] == PREFIX_OPC |=> !rec_valid_o);

  p_nonbranch_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && (rec_class_o < 4'd10 || rec_class_o > 4'd13) |-> rec_offset_o == '0);

  p_bwd_sign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && (rec_class_o == 4'd11 || rec_class_o == 4'd13) && rec_imm_o != '0
      |-> rec_offset_o[OFF_W-1]);

  p_fwd_sign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && (rec_class_o == 4'd10 || rec_class_o == 4'd12) |-> !rec_offset_o[OFF_W-1]);

  p_err_norec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !rec_valid_o);

  p_err_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
endmodule

bind sru6_dec sru6_dec_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hw_valid_i   (hw_valid_i),
  .hw_i         (hw_i),
  .hw_ready_o   (hw_ready_o),
  .rec_valid_o  (rec_valid_o),
  .rec_ready_i  (rec_ready_i),
  .rec_class_o  (rec_class_o),
  .rec_reg_o    (rec_reg_o),
  .rec_imm_o    (rec_imm_o),
  .rec_offset_o (rec_offset_o),
  .rec_long_o   (rec_long_o),
  .err_o        (err_o)
);

// File: tb/sru6_dec_tb.sv
module sru6_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_valid = 1'b0;
  logic [15:0] hw = '0;
  logic        hw_ready;
  logic        rec_valid;
  logic        rec_ready = 1'b1;
  logic [3:0]  rec_class;
  logic [3:0]  rec_reg;
  logic [15:0] rec_imm;
  logic [16:0] rec_off;
  logic        rec_long;
  logic        err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sru6_dec dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .hw_valid_i   (hw_valid),
    .hw_i         (hw),
    .hw_ready_o   (hw_ready),
    .rec_valid_o  (rec_valid),
    .rec_ready_i  (rec_ready),
    .rec_class_o  (rec_class),
    .rec_reg_o    (rec_reg),
    .rec_imm_o    (rec_imm),
    .rec_offset_o (rec_off),
    .rec_long_o   (rec_long),
    .err_o        (err)
  );

  // b0,b1 form the first halfword and b2,b3 the second, with the low byte first (R1)
  typedef struct packed {
    logic [7:0]  b0, b1, b2, b3;
    logic        lng;
    logic [3:0]  cls;
    logic [3:0]  rg;
    logic [15:0] imm;
    logic [16:0] off;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{8'h85, 8'h75, 8'h00, 8'h00, 1'b0, 4'd11, 4'd6,  16'd5,     -17'sd5},
    '{8'h07, 8'hF0, 8'h83, 8'h76, 1'b1, 4'd11, 4'd10, 16'd451,   -17'sd451},
    '{8'h0A, 8'h72, 8'h00, 8'h00, 1'b0, 4'd10, 4'd8,  16'd10,    17'sd10},
    '{8'h64, 8'hF0, 8'h73, 8'h70, 1'b1, 4'd10, 4'd1,  16'd6451,  17'sd6451},
    '{8'h48, 8'h79, 8'h00, 8'h00, 1'b0, 4'd12, 4'd5,  16'd8,     17'sd8},
    '{8'h01, 8'hF0, 8'hA5, 8'h7A, 1'b1, 4'd12, 4'd10, 16'd101,   17'sd101},
    '{8'h85, 8'h7C, 8'h00, 8'h00, 1'b0, 4'd13, 4'd2,  16'd5,     -17'sd5},
    '{8'hFF, 8'hF3, 8'h3F, 8'h66, 1'b1, 4'd6,  4'd8,  16'd65535, 17'sd0},
    '{8'hFF, 8'h62, 8'h00, 8'h00, 1'b0, 4'd5,  4'd11, 16'd63,    17'sd0},
    '{8'hDE, 8'h68, 8'h00, 8'h00, 1'b0, 4'd7,  4'd3,  16'd30,    17'sd0},
    '{8'h0F, 8'hF0, 8'hE8, 8'h6A, 1'b1, 4'd7,  4'd11, 16'd1000,  17'sd0},
    '{8'h04, 8'h6C, 8'h00, 8'h00, 1'b0, 4'd8,  4'd0,  16'd4,     17'sd0},
    '{8'hF9, 8'hF1, 8'h59, 8'h6C, 1'b1, 4'd8,  4'd1,  16'd32345, 17'sd0},
    '{8'h90, 8'h5A, 8'h00, 8'h00, 1'b0, 4'd3,  4'd10, 16'd16,    17'sd0},
    '{8'h33, 8'h5E, 8'h00, 8'h00, 1'b0, 4'd4,  4'd8,  16'd51,    17'sd0},
    '{8'h13, 8'hF0, 8'h09, 8'h5E, 1'b1, 4'd4,  4'd8,  16'd1225,  17'sd0},
    '{8'h64, 8'hE9, 8'h00, 8'h00, 1'b0, 4'd9,  4'd5,  16'd36,    17'sd0},
    '{8'h75, 8'hF2, 8'hB8, 8'hE8, 1'b1, 4'd9,  4'd2,  16'd40312, 17'sd0},
    '{8'h0E, 8'h52, 8'h00, 8'h00, 1'b0, 4'd1,  4'd8,  16'd14,    17'sd0},
    '{8'h0A, 8'hF0, 8'h4E, 8'h52, 1'b1, 4'd1,  4'd9,  16'd654,   17'sd0},
    '{8'h60, 8'h54, 8'h00, 8'h00, 1'b0, 4'd2,  4'd1,  16'd32,    17'sd0},
    '{8'h88, 8'hF0, 8'h39, 8'h54, 1'b1, 4'd2,  4'd0,  16'd8761,  17'sd0},
    '{8'hFF, 8'hF3, 8'hFF, 8'h77, 1'b1, 4'd11, 4'd15, 16'd65535, -17'sd65535},
    '{8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 4'd0,  4'd0,  16'd0,     17'sd0},
    '{8'hCD, 8'hAB, 8'h00, 8'h00, 1'b0, 4'd0,  4'd15, 16'd13,    17'sd0},
    '{8'h01, 8'hF0, 8'h41, 8'h7C, 1'b1, 4'd13, 4'd1,  16'd65,    -17'sd65}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // leaves at the negedge after the accepting edge, valid low
  task automatic send_hw(input logic [15:0] h);
    @(negedge clk);
    hw_valid = 1'b1;
    hw = h;
    while (!hw_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    hw_valid = 1'b0;
  endtask

  task automatic chk_rec(input string req, input logic [3:0] c, input logic [3:0] r,
                         input logic [15:0] i, input logic [16:0] o, input logic l);
    chk({req, " valid"}, 32'(rec_valid), 32'd1);
    chk({req, " class"}, 32'(rec_class), 32'(c));
    chk({req, " reg"},   32'(rec_reg),   32'(r));
    chk({req, " imm"},   32'(rec_imm),   32'(i));
    chk({req, " off"},   32'(rec_off),   32'(o));
    chk({req, " long"},  32'(rec_long),  32'(l));
    chk({req, " err"},   32'(err),       32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 valid at reset", 32'(rec_valid), 32'd0);
    chk("R8 err at reset", 32'(err), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 ready when idle", 32'(hw_ready), 32'd1);

    // table: R1 R2 R3 R4 R5 R9
    for (int k = 0; k < NV; k++) begin
      send_hw({VECS[k].b1, VECS[k].b0});
      if (VECS[k].lng) begin
        chk("R2 prefix yields no record", 32'(rec_valid), 32'd0);
        send_hw({VECS[k].b3, VECS[k].b2});
      end
      chk_rec($sformatf("R3/R4 vec%0d", k), VECS[k].cls, VECS[k].rg,
              VECS[k].imm, VECS[k].off, VECS[k].lng);
    end

    // R6 prefix followed by prefix, then a short halfword carries no stale prefix
    send_hw(16'hF007);
    send_hw(16'hF3FF);
    chk("R6 err after double prefix", 32'(err), 32'd1);
    chk("R6 no record on double prefix", 32'(rec_valid), 32'd0);
    @(negedge clk);
    chk("R6 err is a single pulse", 32'(err), 32'd0);
    send_hw(16'h7683);
    chk_rec("R6 prefix dropped", 4'd11, 4'd10, 16'd3, -17'sd3, 1'b0);

    // R6 prefix followed by unknown opcode
    send_hw(16'hF001);
    send_hw(16'hABCD);
    chk("R6 err after prefix+unknown", 32'(err), 32'd1);
    chk("R6 no record on prefix+unknown", 32'(rec_valid), 32'd0);
    send_hw(16'h68DE);
    chk_rec("R6 after unknown", 4'd7, 4'd3, 16'd30, 17'sd0, 1'b0);

    // R8 reset between prefix and operand
    send_hw(16'hF3FF);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 valid during reset", 32'(rec_valid), 32'd0);
    rst_n = 1'b1;
    send_hw(16'h7683);
    chk_rec("R8 pending cleared", 4'd11, 4'd10, 16'd3, -17'sd3, 1'b0);

    // R7 back-pressure
    @(negedge clk);
    rec_ready = 1'b0;
    send_hw(16'h68DE);
    chk_rec("R7 record before stall", 4'd7, 4'd3, 16'd30, 17'sd0, 1'b0);
    hw_valid = 1'b1;
    hw = 16'h5A90;
    for (int s = 0; s < 3; s++) begin
      chk("R7 ready low while held", 32'(hw_ready), 32'd0);
      @(negedge clk);
      chk_rec("R7 record held", 4'd7, 4'd3, 16'd30, 17'sd0, 1'b0);
    end
    rec_ready = 1'b1;
    @(negedge clk);
    hw_valid = 1'b0;
    chk_rec("R7 next record after release", 4'd3, 4'd10, 16'd16, 17'sd0, 1'b0);
    @(negedge clk);
    chk("R9 record drained", 32'(rec_valid), 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule